// File: doc/BRIEF.md
# I2C Clock-Stretch Wait Controller

This block decides when a byte-oriented I2C engine holds SCL low so that software can service the bus, and when it lets go. The shift engine reports each falling SCL edge together with the number of clocks completed so far in the current byte. At one point in every byte, chosen by a timing-select level, the controller raises an SCL low-hold request. The hold sits either after the last data clock, before the acknowledge bit, or after the acknowledge clock. The hold stays up until software performs an action that counts as a release for the present role and direction.

A receiving side releases through a dedicated release strobe or by writing all-ones to the shift register. A transmitting side releases only by writing a data byte. That byte is passed on to the shift engine over a valid/ready pair. A master may also release by asking for a start or a stop condition. Every release produces a one-cycle operation pulse that tells the bus sequencer what comes next: resume, start or stop. The controller also keeps the level to drive in the acknowledge slot, captured when the acknowledge clock begins. It reports the combined SCL low state when a peer device stretches the clock as well.

The transmit byte interface follows valid/ready rules. `tx_valid` rises the cycle after a transmitter's data-write release. `tx_data` then stays constant until a cycle in which `tx_ready` is high, and `tx_valid` falls after that cycle. A new release that loads a byte replaces a byte still pending. All control and status pins are plain levels or single-cycle strobes.

Top module: `i2c_wait_ctrl`

## Requirements
- R1: With `wait_sel`=0 a wait starts on an `scl_fall` strobe with `bit_cnt`=8. With `wait_sel`=1 it starts on one with `bit_cnt`=9. `wait_active` and `scl_hold` read 1 from the following cycle.
- R2: When `is_tx`=0, a wait ends on `wr_release` or on `wr_shift` with `wr_data`=8'hFF. A `wr_shift` with any other value leaves the wait in place.
- R3: When `is_tx`=1, a wait ends on `wr_shift` with any value. `wr_release` alone has no effect. The written byte appears on `tx_data` with `tx_valid`=1 from the following cycle.
- R4: When `is_master`=1, `req_start` or `req_stop` ends a wait. When `is_master`=0, both are ignored.
- R5: A release gives exactly one `op_valid` pulse, the cycle after the strobe, with `op_kind` 1 for start, 2 for stop and 0 for resume. Start wins over stop, and stop wins over data. A data byte written in the same cycle as a winning start or stop is not loaded.
- R6: `wait_active` and `scl_hold` return to 0 in the cycle after the releasing strobe. Strobes that arrive while no wait is active produce no `op_valid`.
- R7: A release by an all-ones write while receiving never raises `tx_valid`.
- R8: `ack_level` is captured when the acknowledge clock begins: at an `scl_fall` with `bit_cnt`=8 under `wait_sel`=1, or at the release of a wait entered at `bit_cnt`=8. The captured value is 0 when `is_tx`=0 and `ack_en`=1, and 1 otherwise. It holds until the next capture, and it reads 1 after reset.
- R9: No wait starts while `xfer_active`=0. If `xfer_active` falls during a wait, the wait ends with no `op_valid`.
- R10: `scl_low` is 1 whenever `scl_hold` or `peer_hold` is 1, so SCL stays low until both sides have released.
- R11: While `tx_valid`=1 and `tx_ready`=0, `tx_valid` stays 1 and `tx_data` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_active | input | 1 | A transfer owned by this device is in progress |
| is_master | input | 1 | Device currently acts as master |
| is_tx | input | 1 | Device transmits the current data byte |
| scl_fall | input | 1 | One-cycle strobe per completed SCL clock |
| bit_cnt | input | 4 | Clocks completed in the byte (1..9) at `scl_fall` |
| wait_sel | input | 1 | 0: wait after clock 8, 1: wait after clock 9 |
| ack_en | input | 1 | Acknowledge received bytes when 1 |
| wr_release | input | 1 | Software wait-release strobe |
| wr_shift | input | 1 | Software shift-register write strobe |
| wr_data | input | 8 | Byte written with `wr_shift` |
| req_start | input | 1 | Software start-condition request strobe |
| req_stop | input | 1 | Software stop-condition request strobe |
| peer_hold | input | 1 | The other device is stretching SCL |
| tx_ready | input | 1 | Shift engine accepts `tx_data` |
| scl_hold | output | 1 | This device requests SCL held low |
| scl_low | output | 1 | SCL is held low by either side |
| wait_active | output | 1 | A wait is in progress |
| ack_level | output | 1 | SDA level for the acknowledge slot |
| op_valid | output | 1 | One-cycle pulse on a release |
| op_kind | output | 2 | 0 resume, 1 start, 2 stop |
| tx_valid | output | 1 | A byte for the shift engine is pending |
| tx_data | output | 8 | Pending transmit byte |

## Verification
Two functions can fall in the same cycle. The first is release arbitration: a data write, a start request and a stop request can all arrive while a master waits. The second is acknowledge capture: the release of a wait held before the acknowledge clock is also the moment `ack_level` is latched, with `ack_en` changed during that wait. The bench drives all three strobes together, and also stop with data. It judges `op_kind`, the absence of `tx_valid`, and the latched `ack_level` against a behavioural model, cycle by cycle.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
  typedef enum logic [1:0] {
    OP_RESUME = 2'd0,
    OP_START  = 2'd1,
    OP_STOP   = 2'd2
  } op_e;
endpackage

// File: rtl/i2cw_point_det.sv
module i2cw_point_det #(
  parameter int CNT_W = 4,
  parameter int BITS  = 8
) (
  input  logic             xfer_active,
  input  logic             scl_fall,
  input  logic [CNT_W-1:0] bit_cnt,
  input  logic             wait_sel,
  output logic             enter,
  output logic             enter_at_data,
  output logic             ack_clk_free
);
  localparam logic [CNT_W-1:0] DATA_END = CNT_W'(BITS);
  localparam logic [CNT_W-1:0] ACK_END  = CNT_W'(BITS + 1);

  logic at_data, at_ack;
  always_comb begin
    at_data       = xfer_active && scl_fall && (bit_cnt == DATA_END);
    at_ack        = xfer_active && scl_fall && (bit_cnt == ACK_END);
    enter_at_data = at_data && !wait_sel;
    enter         = enter_at_data || (at_ack && wait_sel);
    // ninth clock starts straight away when no wait is placed before it
    ack_clk_free  = at_data && wait_sel;
  end
endmodule

// File: rtl/i2cw_release_arb.sv
module i2cw_release_arb
  import i2cw_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wait_active,
  input  logic              xfer_active,
  input  logic              is_master,
  input  logic              is_tx,
  input  logic              wr_release,
  input  logic              wr_shift,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              req_start,
  input  logic              req_stop,
  output logic              rel_any,
  output op_e               op,
  output logic              load_tx
);
  localparam logic [DATA_W-1:0] ALL_ONES = '1;

  logic live, m_start, m_stop, d_rel;
  always_comb begin
    live    = wait_active && xfer_active;
    m_start = is_master && req_start;
    m_stop  = is_master && req_stop;
    d_rel   = is_tx ? wr_shift : (wr_release || (wr_shift && (wr_data == ALL_ONES)));
    rel_any = live && (m_start || m_stop || d_rel);
    if (m_start)     op = OP_START;
    else if (m_stop) op = OP_STOP;
    else             op = OP_RESUME;
    load_tx = live && is_tx && wr_shift && !m_start && !m_stop;
  end

  // R7: a receiving side never hands a byte to the shift engine
  a_r7_rx_no_load: assert property (@(posedge clk) disable iff (!rst_n)
    !is_tx |-> !load_tx);
  // R4: a slave's start/stop request never releases by itself
  a_r4_slave_req_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_master && !wr_shift && !wr_release) |-> !rel_any);
endmodule

// File: rtl/i2cw_ack_ctl.sv
module i2cw_ack_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_start,
  input  logic is_tx,
  input  logic ack_en,
  output logic ack_level
);
  always_ff @(posedge clk) begin
    if (!rst_n)         ack_level <= 1'b1;
    else if (ack_start) ack_level <= is_tx ? 1'b1 : !ack_en;
  end

  // R8: level only moves when the acknowledge clock begins
  a_r8_ack_held: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_start |=> $stable(ack_level));
endmodule

// File: rtl/i2cw_tx_stage.sv
module i2cw_tx_stage #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else if (load) begin
      tx_valid <= 1'b1;
      tx_data  <= load_data;
    end else if (tx_ready) begin
      tx_valid <= 1'b0;
    end
  end

  // R11: a pending byte is held until the engine takes it
  a_r11_tx_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !load) |=> (tx_valid && $stable(tx_data)));
endmodule

// File: rtl/i2c_wait_ctrl.sv
module i2c_wait_ctrl
  import i2cw_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4,
  parameter int BITS   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_active,
  input  logic              is_master,
  input  logic              is_tx,
  input  logic              scl_fall,
  input  logic [CNT_W-1:0]  bit_cnt,
  input  logic              wait_sel,
  input  logic              ack_en,
  input  logic              wr_release,
  input  logic              wr_shift,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              req_start,
  input  logic              req_stop,
  input  logic              peer_hold,
  input  logic              tx_ready,
  output logic              scl_hold,
  output logic              scl_low,
  output logic              wait_active,
  output logic              ack_level,
  output logic              op_valid,
  output logic [1:0]        op_kind,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data
);
  logic enter, enter_at_data, ack_clk_free;
  logic rel_any, load_tx, wait_at_data, ack_start;
  op_e  op;

  i2cw_point_det #(.CNT_W(CNT_W), .BITS(BITS)) u_point (
    .xfer_active(xfer_active), .scl_fall(scl_fall), .bit_cnt(bit_cnt),
    .wait_sel(wait_sel), .enter(enter), .enter_at_data(enter_at_data),
    .ack_clk_free(ack_clk_free));

  i2cw_release_arb #(.DATA_W(DATA_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .wait_active(wait_active),
    .xfer_active(xfer_active), .is_master(is_master), .is_tx(is_tx),
    .wr_release(wr_release), .wr_shift(wr_shift), .wr_data(wr_data),
    .req_start(req_start), .req_stop(req_stop),
    .rel_any(rel_any), .op(op), .load_tx(load_tx));

  assign ack_start = ack_clk_free || (rel_any && wait_at_data);

  i2cw_ack_ctl u_ack (
    .clk(clk), .rst_n(rst_n), .ack_start(ack_start), .is_tx(is_tx),
    .ack_en(ack_en), .ack_level(ack_level));

  i2cw_tx_stage #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(load_tx), .load_data(wr_data),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wait_active  <= 1'b0;
      wait_at_data <= 1'b0;
      op_valid     <= 1'b0;
      op_kind      <= OP_RESUME;
    end else begin
      op_valid <= rel_any;
      if (rel_any) op_kind <= op;
      if (!xfer_active || rel_any) begin
        wait_active <= 1'b0;
      end else if (enter) begin
        wait_active  <= 1'b1;
        wait_at_data <= enter_at_data;
      end
    end
  end

  assign scl_hold = wait_active;
  assign scl_low  = scl_hold || peer_hold;

  // R9: an idle bus never carries a wait
  a_r9_no_wait_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_active |=> !wait_active);
  // R6: a release empties the wait on the next cycle
  a_r6_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_active && rel_any) |=> (!wait_active && op_valid));
  // R5: a release is reported once only
  a_r5_single_op: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> !op_valid);
  // R10: SCL is low while either side stretches
  a_r10_bus_low: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_hold || peer_hold) |-> scl_low);
endmodule

// File: tb/tb_i2c_wait_ctrl.sv
module tb_i2c_wait_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic xfer_active = 0, is_master = 0, is_tx = 0, scl_fall = 0;
  logic [3:0] bit_cnt = 0;
  logic wait_sel = 0, ack_en = 0, wr_release = 0, wr_shift = 0;
  logic [7:0] wr_data = 0;
  logic req_start = 0, req_stop = 0, peer_hold = 0, tx_ready = 1;
  logic scl_hold, scl_low, wait_active, ack_level, op_valid, tx_valid;
  logic [1:0] op_kind;
  logic [7:0] tx_data;

  always #2 clk = ~clk;

  i2c_wait_ctrl dut (
    .clk(clk), .rst_n(rst_n), .xfer_active(xfer_active), .is_master(is_master),
    .is_tx(is_tx), .scl_fall(scl_fall), .bit_cnt(bit_cnt), .wait_sel(wait_sel),
    .ack_en(ack_en), .wr_release(wr_release), .wr_shift(wr_shift),
    .wr_data(wr_data), .req_start(req_start), .req_stop(req_stop),
    .peer_hold(peer_hold), .tx_ready(tx_ready), .scl_hold(scl_hold),
    .scl_low(scl_low), .wait_active(wait_active), .ack_level(ack_level),
    .op_valid(op_valid), .op_kind(op_kind), .tx_valid(tx_valid),
    .tx_data(tx_data));

  int checks = 0, fails = 0;
  string cur_req = "R1";
  bit done = 0;

  // behavioural reference
  bit m_wait, m_at8, m_opv, m_txv, m_ack;
  int m_op;
  logic [7:0] m_txd;

  always @(posedge clk) begin
    bit s, p, d, rel, ld, first;
    if (!rst_n) begin
      m_wait = 0; m_at8 = 0; m_opv = 0; m_op = 0; m_txv = 0; m_txd = 0; m_ack = 1;
    end else begin
      s = is_master && req_start;
      p = is_master && req_stop;
      if (is_tx) d = wr_shift;
      else d = wr_release || (wr_shift && wr_data == 8'hFF);
      rel = m_wait && xfer_active && (s || p || d);
      ld = rel && is_tx && wr_shift && !s && !p;
      first = xfer_active && scl_fall && bit_cnt == 8 && wait_sel;
      if (first || (rel && m_at8)) m_ack = is_tx ? 1'b1 : !ack_en;
      m_opv = rel;
      if (rel) m_op = s ? 1 : (p ? 2 : 0);
      if (ld) begin m_txv = 1; m_txd = wr_data; end
      else if (tx_ready) m_txv = 0;
      if (!xfer_active || rel) m_wait = 0;
      else if (xfer_active && scl_fall &&
               ((bit_cnt == 8 && !wait_sel) || (bit_cnt == 9 && wait_sel))) begin
        m_wait = 1; m_at8 = !wait_sel;
      end
    end
  end

  task automatic cmp(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      cmp("wait_active", wait_active, m_wait);
      cmp("scl_hold", scl_hold, m_wait);
      cmp("scl_low", scl_low, m_wait || peer_hold);
      cmp("op_valid", op_valid, m_opv);
      if (m_opv) cmp("op_kind", op_kind, m_op);
      cmp("tx_valid", tx_valid, m_txv);
      if (m_txv) cmp("tx_data", tx_data, m_txd);
      cmp("ack_level", ack_level, m_ack);
    end
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic clr();
    scl_fall = 0; wr_release = 0; wr_shift = 0; req_start = 0; req_stop = 0;
  endtask

  task automatic clk_edge(int c);
    bit_cnt = 4'(c); scl_fall = 1; tick(); clr(); tick();
  endtask

  task automatic run_bits(int last);
    for (int i = 1; i <= last; i++) clk_edge(i);
  endtask

  task automatic direct(string tag, bit cond, string what);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s %s: actual 0 expected 1 at %0t", tag, what, $time);
    end
  endtask

  initial begin
    tick(3);
    rst_n = 1; tick();
    // R1/R2: receive, wait before ack
    cur_req = "R1"; xfer_active = 1; wait_sel = 0; ack_en = 1;
    run_bits(8); tick(2);
    direct("R1", wait_active == 1, "wait after clock 8");
    cur_req = "R2"; wr_shift = 1; wr_data = 8'h55; tick(); clr(); tick(2);
    direct("R2", wait_active == 1, "non-FF write ignored");
    wr_release = 1; tick(); clr();
    direct("R6", wait_active == 0 && op_valid == 1, "release next cycle");
    tick(); clk_edge(9);
    // R8/R7: wait after ack, FF release
    cur_req = "R8"; wait_sel = 1; ack_en = 0; run_bits(9); tick();
    direct("R8", ack_level == 1, "nack captured");
    cur_req = "R7"; wr_shift = 1; wr_data = 8'hFF; tick(); clr(); tick();
    direct("R7", tx_valid == 0, "FF release loads nothing");
    // R8: ack_en changed during wait before ack clock
    cur_req = "R8"; wait_sel = 0; ack_en = 0; run_bits(8); ack_en = 1; tick(2);
    wr_release = 1; tick(); clr(); tick();
    direct("R8", ack_level == 0, "ack set during wait");
    wait_sel = 1; clk_edge(9); tick();
    // R3/R11: transmitter
    cur_req = "R3"; is_tx = 1; run_bits(9);
    wr_release = 1; tick(); clr(); tick();
    direct("R3", wait_active == 1, "release strobe ignored in tx");
    cur_req = "R11"; tx_ready = 0; wr_shift = 1; wr_data = 8'hA5; tick(); clr(); tick(4);
    direct("R11", tx_valid == 1 && tx_data == 8'hA5, "byte held");
    tx_ready = 1; tick(2);
    // R4: slave start ignored, master start/stop
    cur_req = "R4"; run_bits(9); req_start = 1; req_stop = 1; tick(); clr(); tick();
    direct("R4", wait_active == 1, "slave request ignored");
    cur_req = "R5"; is_master = 1; req_start = 1; req_stop = 1; wr_shift = 1; wr_data = 8'h3C;
    tick(); clr();
    direct("R5", op_valid == 1 && op_kind == 2'd1, "start wins");
    tick(2);
    run_bits(9); req_stop = 1; wr_shift = 1; wr_data = 8'h11; tick(); clr();
    direct("R5", op_kind == 2'd2, "stop beats data");
    tick(2);
    cur_req = "R6"; wr_release = 1; wr_shift = 1; tick(); clr(); tick();
    direct("R6", op_valid == 0, "no op outside wait");
    // R9: idle bus
    cur_req = "R9"; xfer_active = 0; run_bits(9); tick();
    direct("R9", wait_active == 0, "no wait when idle");
    xfer_active = 1; run_bits(9); xfer_active = 0; tick(2);
    direct("R9", wait_active == 0 && op_valid == 0, "drop clears silently");
    // R10: peer stretch
    cur_req = "R10"; xfer_active = 1; is_master = 0; peer_hold = 1; run_bits(9);
    wr_shift = 1; tick(); clr(); tick();
    direct("R10", scl_low == 1, "peer keeps SCL low");
    peer_hold = 0; tick(2);
    direct("R10", scl_low == 0, "both released");
    tick(3);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule